// File: doc/BRIEF.md
# Dataflow Operand Matching Unit

This block sits between the token queue and the instruction fetch stage of a tagged dataflow node. Every token carries a data value, a context tag and the address of the instruction that consumes it, plus a bit saying whether it is the left or the right operand, and a bit marking single-operand (monadic) instructions. No program counter is involved: an instruction runs only once all of its operands are present.

The first operand of a two-input instruction waits in a small associative store. When the partner operand arrives with the same tag, the same instruction address and the opposite side bit, the waiting entry is freed and the pair is sent out as a fire packet, with the left operand in the first slot. Monadic tokens bypass the store and fire at once. Different tags keep several live activations of one instruction apart. When the store has no free entry, the input stalls for any token that would need one.

Top module: `dataflow_match_unit`

## Requirements
- R1: After reset the store is empty, `in_ready` is 1 and `fire_valid` is 0.
- R2: An accepted token with `in_mono`=1 produces `fire_valid`=1 in the next cycle with `fire_left` = its data, `fire_right` = 0, `fire_mono` = 1 and its tag and address.
- R3: An accepted two-operand token with no waiting partner is stored and produces no fire packet.
- R4: A token whose tag and address equal those of a waiting token on the opposite side (`in_port` 0 = left, 1 = right) fires in the next cycle. `fire_left` carries the left operand and `fire_right` the right operand, whatever their arrival order, and `fire_mono` is 0.
- R5: Tokens that share an address but carry different tags never match one another, so each activation pairs only with its own partner.
- R6: Tokens that share a tag but carry different addresses never match one another.
- R7: Two tokens on the same side with the same tag and address do not match. Both are stored.
- R8: The store holds DEPTH entries (16 by default). When it is full, `in_ready` is 0 for a two-operand token without a partner, and 1 for a monadic token or for a token that has a partner waiting.
- R9: A matched entry is freed in the cycle its partner is accepted. A later token with the same tag, address and side as that partner is then stored and does not fire.
- R10: When no token is accepted in a cycle, `fire_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Token can be accepted this cycle |
| in_data | input | DW | Operand value |
| in_tag | input | TW | Context tag |
| in_addr | input | AW | Target instruction address |
| in_port | input | 1 | Operand side: 0 left, 1 right |
| in_mono | input | 1 | Single-operand instruction |
| fire_valid | output | 1 | Fire packet valid |
| fire_left | output | DW | Left operand (the data for monadic) |
| fire_right | output | DW | Right operand (0 for monadic) |
| fire_tag | output | TW | Tag of the firing activation |
| fire_addr | output | AW | Address of the firing instruction |
| fire_mono | output | 1 | Packet came from a monadic token |

## Verification
Operand pairs are sent left-first and right-first, so a swap in the packet ordering shows up. Near misses that differ only in tag, only in address or only in side are sent to show that every field takes part in the match. The store is filled to capacity, and then a non-matching token, a monadic token and a matching partner are offered, which separates the stall rule from the bypass and release paths. A token that repeats an already matched partner shows whether the entry was really freed. A behavioural queue model predicts `in_ready` and the fire packet on every cycle.

// File: rtl/dataflow_match_unit.sv
module dataflow_match_unit #(
  parameter int DW    = 16,
  parameter int TW    = 4,
  parameter int AW    = 6,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [TW-1:0] in_tag,
  input  logic [AW-1:0] in_addr,
  input  logic          in_port,
  input  logic          in_mono,
  output logic          fire_valid,
  output logic [DW-1:0] fire_left,
  output logic [DW-1:0] fire_right,
  output logic [TW-1:0] fire_tag,
  output logic [AW-1:0] fire_addr,
  output logic          fire_mono
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] hit_vec;
  logic [DW-1:0]    sdata [DEPTH];
  logic [TW-1:0]    stag  [DEPTH];
  logic [AW-1:0]    saddr [DEPTH];
  logic [DEPTH-1:0] sport;
  logic [IW-1:0]    hidx, fidx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && stag[i] == in_tag && saddr[i] == in_addr && sport[i] != in_port;
  end

  always_comb begin
    hidx = '0;
    fidx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hidx = IW'(i);
      if (!vld[i])    fidx = IW'(i);
    end
  end

  wire any_hit = |hit_vec;
  wire full    = &vld;
  wire take    = in_valid && in_ready;
  wire pair    = take && !in_mono && any_hit;
  wire store   = take && !in_mono && !any_hit;

  assign in_ready = in_mono || any_hit || !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld        <= '0;
      fire_valid <= 1'b0;
    end else begin
      fire_valid <= take && (in_mono || any_hit);
      if (pair)  vld[hidx] <= 1'b0;
      if (store) vld[fidx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      sdata[fidx] <= in_data;
      stag[fidx]  <= in_tag;
      saddr[fidx] <= in_addr;
      sport[fidx] <= in_port;
    end
    if (take) begin
      fire_tag  <= in_tag;
      fire_addr <= in_addr;
      fire_mono <= in_mono;
      if (in_mono) begin
        fire_left  <= in_data;
        fire_right <= '0;
      end else if (in_port) begin
        fire_left  <= sdata[hidx];
        fire_right <= in_data;
      end else begin
        fire_left  <= in_data;
        fire_right <= sdata[hidx];
      end
    end
  end

  assert_mono_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mono |=> fire_valid && fire_mono);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !fire_valid);

  assert_store_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> !fire_valid && $countones(vld) == $past($countones(vld)) + 1);

  assert_match_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pair |=> fire_valid && !fire_mono && $countones(vld) + 1 == $past($countones(vld)));

  assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !in_mono && $countones(vld) == DEPTH);
endmodule

// File: tb/tb_dataflow_match_unit.sv
module tb_dataflow_match_unit;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_port = 0, in_mono = 0;
  logic [15:0] in_data = 0;
  logic [3:0]  in_tag = 0;
  logic [5:0]  in_addr = 0;
  logic        in_ready, fire_valid, fire_mono;
  logic [15:0] fire_left, fire_right;
  logic [3:0]  fire_tag;
  logic [5:0]  fire_addr;

  dataflow_match_unit dut (.*);

  always #10 clk = ~clk;

  typedef struct { logic [15:0] d; logic [3:0] t; logic [5:0] a; logic p; } tok_t;
  tok_t q[$];
  int checks = 0, errors = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    q.delete();
  endtask

  task automatic step(string req, logic v, logic [15:0] d, logic [3:0] t,
                      logic [5:0] a, logic p, logic m);
    logic er, ev; logic [15:0] el, erg; int hi;
    in_valid = v; in_data = d; in_tag = t; in_addr = a; in_port = p; in_mono = m;
    #1;
    hi = -1;
    foreach (q[i]) if (hi < 0 && q[i].t == t && q[i].a == a && q[i].p != p) hi = i;
    er = m || hi >= 0 || q.size() < 16;
    chk(req, "in_ready", in_ready, er);
    ev = 0; el = 0; erg = 0;
    if (v && er) begin
      if (m) begin ev = 1; el = d; erg = 0; end
      else if (hi >= 0) begin
        ev = 1;
        if (p) begin el = q[hi].d; erg = d; end else begin el = d; erg = q[hi].d; end
        q.delete(hi);
      end else q.push_back('{d, t, a, p});
    end
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk(req, "fire_valid", fire_valid, ev);
    if (ev) begin
      chk(req, "fire_left", fire_left, el);
      chk(req, "fire_right", fire_right, erg);
      chk(req, "fire_tag", fire_tag, t);
      chk(req, "fire_addr", fire_addr, a);
      chk(req, "fire_mono", fire_mono, m);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "fire_valid", fire_valid, 0);
    step("R10", 0, 16'h1111, 1, 1, 0, 0);
    step("R2", 1, 16'hABCD, 2, 5, 0, 1);
    step("R2", 1, 16'h0042, 7, 9, 1, 1);
    // R3 then R4, right operand first and left operand first
    step("R3", 1, 16'h00B0, 3, 4, 1, 0);
    step("R4", 1, 16'h00A0, 3, 4, 0, 0);
    step("R3", 1, 16'h0C00, 5, 6, 0, 0);
    step("R4", 1, 16'h0D00, 5, 6, 1, 0);
    // R5: two activations of one instruction
    step("R5", 1, 16'h0101, 1, 8, 0, 0);
    step("R5", 1, 16'h0202, 2, 8, 0, 0);
    step("R5", 1, 16'h0302, 2, 8, 1, 0);
    step("R5", 1, 16'h0301, 1, 8, 1, 0);
    // R6: same tag, different address
    step("R6", 1, 16'h0401, 4, 10, 0, 0);
    step("R6", 1, 16'h0402, 4, 11, 1, 0);
    step("R6", 1, 16'h0403, 4, 10, 1, 0);
    step("R6", 1, 16'h0404, 4, 11, 0, 0);
    // R9: matched entry really freed
    step("R9", 1, 16'h0501, 6, 12, 0, 0);
    step("R9", 1, 16'h0502, 6, 12, 1, 0);
    step("R9", 1, 16'h0503, 6, 12, 1, 0);
    step("R9", 1, 16'h0504, 6, 12, 0, 0);
    // R7: same side does not match
    do_reset();
    step("R7", 1, 16'h0601, 9, 20, 0, 0);
    step("R7", 1, 16'h0602, 9, 20, 0, 0);
    step("R7", 1, 16'h0603, 9, 20, 0, 0);
    // R8: fill the store
    do_reset();
    for (int i = 0; i < 16; i++) step("R8", 1, 16'h1000 + 16'(i), 4'(i), 1, 0, 0);
    step("R8", 1, 16'h2000, 3, 2, 0, 0);
    step("R8", 1, 16'h2001, 3, 1, 0, 0);
    step("R8", 1, 16'h2002, 0, 3, 0, 1);
    step("R8", 1, 16'h2003, 3, 1, 1, 0);
    step("R8", 1, 16'h2004, 3, 2, 0, 0);
    step("R8", 1, 16'h2005, 8, 2, 1, 0);
    step("R10", 0, 16'h2006, 5, 1, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule